// File: doc/BRIEF.md
# Accumulator Repacking Sequencer

This block holds four wide accumulators. Each one is logically a 32-bit main value with two 8-bit extension bytes, one low and one high. Each accumulator is kept as a single packed storage word, and the layout of that word depends on the arithmetic mode held in a small mode register. In the fractional layout the main value sits above the low extension byte. In the two integer layouts (signed and unsigned) the low extension byte sits above the main value. The high extension byte is always at the top of the 48 logical bits. The storage bits above those 48 bits carry a sign extension of bit 47, or zeros in unsigned mode.

When a write to the mode register changes the fractional bit or the signed bit, the stored words would no longer match the new mode. The block then walks through the accumulators in index order, one per clock, and rewrites each one into the new layout. It keeps `busy` high while it does this, and it commits the new mode value only after the last accumulator has been rewritten. A write that leaves both mode bits unchanged updates the register at once. While `busy` is high, every write is refused, so a requester holds its write until `busy` falls.

Top module: `acc_repack`

## Requirements
- R1: After reset all four stored words read zero, the mode register reads zero and `busy` is low.
- R2: When idle, `acc_wr_en` stores the 48-bit `acc_wr_data` into accumulator `acc_sel`. It is extended upward to the storage width: with zeros when mode bits [1:0] are both 0, and with copies of data bit 47 otherwise. `acc_rd_data` shows the stored word of `acc_sel` in the same cycle.
- R3: An idle mode write whose bits [1:0] equal the current ones loads `sr_wr_data` into `sr_q` at the next edge and leaves `busy` low.
- R4: An idle mode write that changes bit 0 (fractional) or bit 1 (signed) raises `busy` for exactly four cycles. `sr_q` keeps its old value during those cycles and takes the written value at the edge where `busy` falls.
- R5: The fractional layout (new bit 0 = 1) is {sign fill, high byte, main[31:0], low byte} with the main value at bits 39:8 and the low byte at bits 7:0.
- R6: The signed layout (new bits [1:0] = 2'b10) is {sign fill, high byte, low byte, main[31:0]} with the low byte at bits 39:32.
- R7: The unsigned layout (new bits [1:0] = 2'b00) is the same as the signed layout but with bits 63:48 forced to zero. When idle in this mode, every stored word has zero upper bits.
- R8: Bit 0 takes priority: bits [1:0] = 2'b11 select the fractional layout. A change of bit 1 alone still starts a four-cycle rewrite.
- R9: Mode and accumulator writes presented while `busy` is high have no effect.
- R10: Accumulator k is rewritten at the (k+1)-th edge after the accepting edge, so accumulator 0 shows its new layout while accumulator 1 still shows its old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_wr_en | input | 1 | Mode register write request |
| sr_wr_data | input | 8 | Mode register write value; bit 0 fractional, bit 1 signed |
| sr_q | output | 8 | Current committed mode register |
| mode_frac | output | 1 | Committed fractional mode bit |
| mode_signed | output | 1 | Committed signed mode bit |
| busy | output | 1 | Rewrite in progress; writes refused |
| acc_sel | input | 2 | Accumulator index for read and write |
| acc_wr_en | input | 1 | Accumulator write request |
| acc_wr_data | input | 48 | Logical packed value to store |
| acc_rd_data | output | 64 | Stored word of the selected accumulator |

## Verification
The hardest state to reach from the ports is the middle of a rewrite, where some accumulators already hold the new layout and the rest still hold the old one, while refused writes are being presented. The stimulus loads distinct patterns with set sign bits and starts a mode change. It then moves `acc_sel` between neighbouring indices edge by edge, and drives a mode write and an accumulator write while `busy` is high. A random phase follows that mixes mode changes, idle writes and writes that collide with `busy`, against a behavioural reference model.

// File: rtl/acc_repack.sv
module acc_repack #(
  parameter int NUM_ACC = 4,
  parameter int MAIN_W  = 32,
  parameter int EXT_W   = 8,
  parameter int STORE_W = 64,
  parameter int SR_W    = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sr_wr_en,
  input  logic [SR_W-1:0]                   sr_wr_data,
  output logic [SR_W-1:0]                   sr_q,
  output logic                              mode_frac,
  output logic                              mode_signed,
  output logic                              busy,
  input  logic [$clog2(NUM_ACC)-1:0]        acc_sel,
  input  logic                              acc_wr_en,
  input  logic [MAIN_W+2*EXT_W-1:0]         acc_wr_data,
  output logic [STORE_W-1:0]                acc_rd_data
);
  localparam int LOG_W = MAIN_W + 2*EXT_W;
  localparam int IDX_W = $clog2(NUM_ACC);
  localparam int PAD_W = STORE_W - LOG_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ACC - 1);

  logic [STORE_W-1:0] acc [NUM_ACC];
  logic [SR_W-1:0]    pend;
  logic [IDX_W-1:0]   idx;
  logic               mode_change;

  function automatic logic [STORE_W-1:0] widen(input logic [LOG_W-1:0] v, input logic zfill);
    return zfill ? {{PAD_W{1'b0}}, v} : {{PAD_W{v[LOG_W-1]}}, v};
  endfunction

  function automatic logic [STORE_W-1:0] repack(input logic [LOG_W-1:0] w, input logic old_f,
                                                input logic new_f, input logic new_s);
    logic [EXT_W-1:0]  hi, lo;
    logic [MAIN_W-1:0] mn;
    logic [LOG_W-1:0]  p;
    hi = w[LOG_W-1 -: EXT_W];
    mn = old_f ? w[EXT_W +: MAIN_W] : w[MAIN_W-1:0];
    lo = old_f ? w[EXT_W-1:0] : w[MAIN_W +: EXT_W];
    p  = new_f ? {hi, mn, lo} : {hi, lo, mn};
    return widen(p, !new_f && !new_s);
  endfunction

  assign mode_frac   = sr_q[0];
  assign mode_signed = sr_q[1];
  assign mode_change = sr_wr_data[1:0] != sr_q[1:0];
  assign acc_rd_data = acc[acc_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      sr_q <= '0;
      pend <= '0;
      for (int i = 0; i < NUM_ACC; i++) acc[i] <= '0;
    end else if (busy) begin
      acc[idx] <= repack(acc[idx][LOG_W-1:0], sr_q[0], pend[0], pend[1]);
      if (idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
        sr_q <= pend;
      end else begin
        idx <= idx + 1'b1;
      end
    end else begin
      if (acc_wr_en) acc[acc_sel] <= widen(acc_wr_data, !sr_q[0] && !sr_q[1]);
      if (sr_wr_en) begin
        if (mode_change) begin
          busy <= 1'b1;
          pend <= sr_wr_data;
        end else begin
          sr_q <= sr_wr_data;
        end
      end
    end
  end
endmodule

module acc_repack_chk #(
  parameter int NUM_ACC = 4,
  parameter int STORE_W = 64,
  parameter int SR_W    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               sr_wr_en,
  input logic [SR_W-1:0]    sr_wr_data,
  input logic [SR_W-1:0]    sr_q,
  input logic [STORE_W-1:0] acc_rd_data
);
  logic [7:0] run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else run <= busy ? run + 8'd1 : 8'd0;

  AST_SAME_MODE_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_en && !busy && sr_wr_data[1:0] == sr_q[1:0]) |=> (!busy && sr_q == $past(sr_wr_data))); // R3
  AST_CHANGE_STARTS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_en && !busy && sr_wr_data[1:0] != sr_q[1:0]) |=> busy); // R4
  AST_MODE_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(sr_q))); // R9
  AST_WALK_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < 8'(NUM_ACC))); // R4
  AST_UNSIGNED_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sr_q[1:0] == 2'b00) |-> (acc_rd_data[STORE_W-1:48] == '0)); // R7
  AST_SIGNED_FILL_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sr_q[1:0] != 2'b00) |-> (acc_rd_data[STORE_W-1:48] == {(STORE_W-48){acc_rd_data[47]}})); // R5
endmodule

bind acc_repack acc_repack_chk #(.NUM_ACC(NUM_ACC), .STORE_W(STORE_W), .SR_W(SR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sr_wr_en(sr_wr_en),
  .sr_wr_data(sr_wr_data), .sr_q(sr_q), .acc_rd_data(acc_rd_data));

// File: tb/sim_acc_repack.sv
module sim_acc_repack;
  localparam int CLK_PER = 10;

  logic        clk = 0, rst_n = 0;
  logic        sr_wr_en = 0, acc_wr_en = 0;
  logic [7:0]  sr_wr_data = 0;
  logic [1:0]  acc_sel = 0;
  logic [47:0] acc_wr_data = 0;
  logic [7:0]  sr_q;
  logic        mode_frac, mode_signed, busy;
  logic [63:0] acc_rd_data;

  acc_repack u0 (.clk(clk), .rst_n(rst_n), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .sr_q(sr_q), .mode_frac(mode_frac), .mode_signed(mode_signed), .busy(busy),
    .acc_sel(acc_sel), .acc_wr_en(acc_wr_en), .acc_wr_data(acc_wr_data),
    .acc_rd_data(acc_rd_data));

  always #(CLK_PER/2) clk = ~clk;

  int    n_chk = 0, n_bad = 0, cyc = 0;
  bit    finished = 0;
  string cur_req = "R1";

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference
  bit [63:0] m_acc [4];
  bit [7:0]  m_sr = 0, m_pend = 0;
  int        m_left = 0;

  function automatic bit [63:0] m_fill(bit [47:0] v, bit zero);
    bit [63:0] r = {16'h0, v};
    if (!zero && v[47]) r[63:48] = 16'hFFFF;
    return r;
  endfunction

  function automatic bit [63:0] m_conv(bit [63:0] w, bit [7:0] from, bit [7:0] to);
    bit [7:0] hi, lo; bit [31:0] mn; bit [47:0] p;
    hi = 8'(w >> 40);
    if (from[0]) begin mn = 32'(w >> 8);  lo = 8'(w); end
    else         begin mn = 32'(w);       lo = 8'(w >> 32); end
    if (to[0]) p = (48'(hi) << 40) | (48'(mn) << 8) | 48'(lo);
    else       p = (48'(hi) << 40) | (48'(lo) << 32) | 48'(mn);
    return m_fill(p, to[1:0] == 2'b00);
  endfunction

  initial foreach (m_acc[i]) m_acc[i] = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      foreach (m_acc[i]) m_acc[i] = 0;
      m_sr = 0; m_pend = 0; m_left = 0;
    end else if (m_left > 0) begin
      m_acc[4-m_left] = m_conv(m_acc[4-m_left], m_sr, m_pend);
      m_left--;
      if (m_left == 0) m_sr = m_pend;
    end else begin
      if (acc_wr_en) m_acc[acc_sel] = m_fill(acc_wr_data, m_sr[1:0] == 2'b00);
      if (sr_wr_en) begin
        if (sr_wr_data[1:0] != m_sr[1:0]) begin m_pend = sr_wr_data; m_left = 4; end
        else m_sr = sr_wr_data;
      end
    end
  end

  always @(negedge clk) if (!finished) begin
    check({cur_req, " busy"}, 64'(busy), 64'(m_left != 0));
    check({cur_req, " mode"}, 64'(sr_q), 64'(m_sr));
    check({cur_req, " read"}, acc_rd_data, m_acc[acc_sel]);
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic rd(int s, string req, logic [63:0] exp);
    acc_sel = 2'(s); #1; check(req, acc_rd_data, exp);
  endtask
  task automatic wr_acc(int s, logic [47:0] d);
    acc_sel = 2'(s); acc_wr_data = d; acc_wr_en = 1; step(); acc_wr_en = 0;
  endtask
  task automatic wr_mode(logic [7:0] d);
    sr_wr_data = d; sr_wr_en = 1; step(); sr_wr_en = 0;
  endtask
  task automatic settle(); while (busy) step(); endtask
  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    wait (cyc > 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
    summary();
  end

  initial begin
    repeat (3) step();
    cur_req = "R1";
    check("R1 busy", 64'(busy), 0);
    check("R1 mode", 64'(sr_q), 0);
    for (int i = 0; i < 4; i++) rd(i, "R1 zero acc", 0);
    rst_n = 1; step();

    cur_req = "R2";
    wr_acc(0, 48'hA53C_1234_5678);
    wr_acc(1, 48'h7F00_1122_3344);
    wr_acc(2, 48'h80FF_0000_0001);
    rd(0, "R2 unsigned store", 64'h0000_A53C_1234_5678);
    rd(2, "R2 unsigned store top", 64'h0000_80FF_0000_0001);

    cur_req = "R3";
    wr_mode(8'hF0);
    check("R3 mode loaded", 64'(sr_q), 64'hF0);
    check("R3 no busy", 64'(busy), 0);

    cur_req = "R10";
    wr_mode(8'hF1);
    check("R4 busy after accept", 64'(busy), 1);
    rd(0, "R10 acc0 old before first edge", 64'h0000_A53C_1234_5678);
    step();
    rd(0, "R10 acc0 converted", 64'hFFFF_A512_3456_783C);
    rd(1, "R10 acc1 still old", 64'h0000_7F00_1122_3344);
    cur_req = "R9";
    acc_sel = 3; acc_wr_data = 48'hFFFF_FFFF_FFFF; acc_wr_en = 1;
    sr_wr_data = 8'h02; sr_wr_en = 1;
    step();
    check("R4 busy mid walk", 64'(busy), 1);
    check("R4 mode held", 64'(sr_q), 64'hF0);
    step();
    acc_wr_en = 0; sr_wr_en = 0;
    check("R4 busy last cycle", 64'(busy), 1);
    step();
    check("R4 busy dropped after four", 64'(busy), 0);
    check("R4 mode committed", 64'(sr_q), 64'hF1);
    rd(3, "R9 acc write while busy ignored", 64'h0);
    rd(2, "R5 fractional sign fill", 64'hFFFF_8000_0000_01FF);

    cur_req = "R6";
    wr_mode(8'h02); settle();
    check("R9 busy-time mode write ignored", 64'(sr_q), 64'h02);
    rd(0, "R6 signed layout", 64'hFFFF_A53C_1234_5678);
    rd(2, "R6 signed layout acc2", 64'hFFFF_80FF_0000_0001);
    cur_req = "R2";
    wr_acc(1, 48'h8000_0000_0000);
    rd(1, "R2 signed mode sign fill", 64'hFFFF_8000_0000_0000);

    cur_req = "R8";
    wr_mode(8'h03); settle();
    rd(0, "R8 frac priority", 64'hFFFF_A512_3456_783C);
    wr_mode(8'h01);
    check("R8 signed-bit change starts walk", 64'(busy), 1);
    settle();
    rd(0, "R8 frac to frac unchanged", 64'hFFFF_A512_3456_783C);

    cur_req = "R7";
    wr_mode(8'h00); settle();
    rd(0, "R7 unsigned layout", 64'h0000_A53C_1234_5678);
    rd(1, "R7 unsigned zero top", 64'h0000_8000_0000_0000);

    cur_req = "R4";
    for (int k = 0; k < 600; k++) begin
      acc_sel     = 2'($urandom);
      acc_wr_data = {$urandom, $urandom} >> 16;
      acc_wr_en   = ($urandom % 3) == 0;
      sr_wr_data  = 8'($urandom);
      sr_wr_en    = ($urandom % 5) == 0;
      step();
    end
    acc_wr_en = 0; sr_wr_en = 0;
    settle(); step();
    summary();
  end
endmodule